// File: doc/BRIEF.md
# Two-Phase Fork and Join Controller

This block provides the two merging elements needed to build non-linear pipelines that use transition signalling. Every handshake wire is a toggle: a request or acknowledge event is any change of level, rising or falling, and there is no return to zero. The fork side takes one word and its request from a single producer and presents both to two consumer branches. It then collects one acknowledge toggle from each branch and turns them into a single acknowledge toward the producer. The join side takes two producers, each with its own request and data field. It raises one combined request toward a single consumer, carrying a word that concatenates both fields, and sends that consumer's acknowledge back to both producers.

The combining is done by a multi-input C-element. Its state follows its inputs only when all of them agree, and otherwise keeps its last value. The block is modelled in one clock domain. Each C-element is a register updated on the clock edge, so a combined event appears one clock edge after the last contributing toggle has been seen. Choosing between competing producers is not part of this block.

Top module: `tp_forkjoin`

## Requirements
- R1: When reset is released, the fork's producer acknowledge, the join's combined request, both join producer acknowledges and the join output word are all zero.
- R2: The fork's data and request inputs appear unchanged, in the same cycle, on the request of each branch (bit 0 is branch A, bit 1 is branch B) and on the shared branch data output.
- R3: The fork's producer acknowledge changes one clock edge after the second of the two branch acknowledges has toggled to match the first.
- R4: While only one branch acknowledge has toggled, the fork's producer acknowledge keeps its value.
- R5: The join's combined request changes one clock edge after both producer requests have toggled. While only one has toggled, the combined request keeps its value.
- R6: The join output word is producer A's field in the upper half and producer B's field in the lower half. It is captured on the edge where the combined request changes, and it stays stable until the next change, whatever the producer fields do in between.
- R7: The consumer acknowledge of the join appears, in the same cycle, on the acknowledge outputs to both producers.
- R8: When the fork feeds the join through two branches that stall independently, every word arrives reassembled, and the producer sees exactly one acknowledge per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fk_src_req | input | 1 | Fork producer request toggle |
| fk_src_data | input | W | Fork producer data |
| fk_src_ack | output | 1 | Fork combined acknowledge to producer |
| fk_br_req | output | 2 | Request toggle to each branch |
| fk_br_data | output | W | Data to both branches |
| fk_br_ack | input | 2 | Acknowledge toggle from each branch |
| jn_a_req | input | 1 | Join producer A request toggle |
| jn_a_data | input | W | Join producer A field |
| jn_a_ack | output | 1 | Acknowledge to producer A |
| jn_b_req | input | 1 | Join producer B request toggle |
| jn_b_data | input | W | Join producer B field |
| jn_b_ack | output | 1 | Acknowledge to producer B |
| jn_dst_req | output | 1 | Join combined request toggle |
| jn_dst_data | output | 2W | Concatenated word {A, B} |
| jn_dst_ack | input | 1 | Acknowledge toggle from consumer |

## Verification
The bench lets one branch acknowledge or one join request toggle on its own and holds it there for several cycles. A design that merged with OR or XOR logic instead of agreement would then fire early and lose one of the two events. It also changes a producer field after capture but without a new request, which exposes a join register that follows its inputs instead of loading only on the combined event. The fork is then connected through two branches with different stall patterns, so both toggle directions and both arrival orders occur. A swapped field order, a missed phase or a duplicated acknowledge shows up as a wrong word or a wrong acknowledge count.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic {
        BR_A = 1'b0,
        BR_B = 1'b1
    } br_e;

    localparam int unsigned NUM_BR = 2;

    // Next state of a C-element: follow the shared input level only on agreement.
    function automatic logic c_update(input logic agree, input logic level, input logic prev);
        return agree ? level : prev;
    endfunction

endpackage

// File: rtl/tp_celem.sv
module tp_celem #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] in_t,
    output logic         y
);
    logic agree;

    assign agree = (in_t == {N{in_t[0]}});

    always_ff @(posedge clk) begin
        if (rst) y <= 1'b0;
        else     y <= tp_pkg::c_update(agree, in_t[0], y);
    end

    // R3 / R5: the state only moves to a level that every input held on the previous edge
    a_r3_r5_agree: assert property (@(posedge clk) disable iff (rst)
        (y != $past(y)) |-> ($past(in_t) == {N{y}}));

    // R3 / R5: an input that has toggled must wait for its partners before toggling again
    for (genvar i = 0; i < N; i++) begin : g_proto
        a_r3_r5_no_double_toggle: assert property (@(posedge clk) disable iff (rst)
            ((in_t[i] != y) && (in_t != {N{in_t[i]}})) |=> $stable(in_t[i]));
    end
endmodule

// File: rtl/tp_fork.sv
module tp_fork #(
    parameter int unsigned W  = 8,
    parameter int unsigned NB = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          src_req,
    input  logic [W-1:0]  src_data,
    output logic          src_ack,
    output logic [NB-1:0] br_req,
    output logic [W-1:0]  br_data,
    input  logic [NB-1:0] br_ack
);
    for (genvar b = 0; b < NB; b++) begin : g_fan
        assign br_req[b] = src_req;
    end
    assign br_data = src_data;

    tp_celem #(.N(NB)) u_ack_merge (
        .clk  (clk),
        .rst  (rst),
        .in_t (br_ack),
        .y    (src_ack)
    );
endmodule

// File: rtl/tp_join.sv
module tp_join #(
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           a_req,
    input  logic [W-1:0]   a_data,
    output logic           a_ack,
    input  logic           b_req,
    input  logic [W-1:0]   b_data,
    output logic           b_ack,
    output logic           dst_req,
    output logic [2*W-1:0] dst_data,
    input  logic           dst_ack
);
    localparam int unsigned OW = 2 * W;

    logic fire;

    tp_celem #(.N(tp_pkg::NUM_BR)) u_req_merge (
        .clk  (clk),
        .rst  (rst),
        .in_t ({b_req, a_req}),
        .y    (dst_req)
    );

    assign fire = (a_req == b_req) && (a_req != dst_req);

    always_ff @(posedge clk) begin
        if (rst)       dst_data <= '0;
        else if (fire) dst_data <= {a_data, b_data};
    end

    assign a_ack = dst_ack;
    assign b_ack = dst_ack;

    // R6: the word captured with a request event holds both fields seen on that edge
    a_r6_capture: assert property (@(posedge clk) disable iff (rst)
        $changed(dst_req) |-> (dst_data == {$past(a_data), $past(b_data)}));

    // R6: with no request event the output word does not move
    a_r6_data_stable: assert property (@(posedge clk) disable iff (rst)
        (dst_req == $past(dst_req)) |-> $stable(dst_data));

    if (OW != 2 * W) begin : g_bad_width
        initial $error("tp_join width mismatch");
    end
endmodule

// File: rtl/tp_forkjoin.sv
module tp_forkjoin #(
    parameter int unsigned W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fk_src_req,
    input  logic [W-1:0]   fk_src_data,
    output logic           fk_src_ack,
    output logic [1:0]     fk_br_req,
    output logic [W-1:0]   fk_br_data,
    input  logic [1:0]     fk_br_ack,
    input  logic           jn_a_req,
    input  logic [W-1:0]   jn_a_data,
    output logic           jn_a_ack,
    input  logic           jn_b_req,
    input  logic [W-1:0]   jn_b_data,
    output logic           jn_b_ack,
    output logic           jn_dst_req,
    output logic [2*W-1:0] jn_dst_data,
    input  logic           jn_dst_ack
);
    tp_fork #(.W(W), .NB(tp_pkg::NUM_BR)) u_fork (
        .clk      (clk),
        .rst      (rst),
        .src_req  (fk_src_req),
        .src_data (fk_src_data),
        .src_ack  (fk_src_ack),
        .br_req   (fk_br_req),
        .br_data  (fk_br_data),
        .br_ack   (fk_br_ack)
    );

    tp_join #(.W(W)) u_join (
        .clk      (clk),
        .rst      (rst),
        .a_req    (jn_a_req),
        .a_data   (jn_a_data),
        .a_ack    (jn_a_ack),
        .b_req    (jn_b_req),
        .b_data   (jn_b_data),
        .b_ack    (jn_b_ack),
        .dst_req  (jn_dst_req),
        .dst_data (jn_dst_data),
        .dst_ack  (jn_dst_ack)
    );

    // R7: both producers of the join always see the same acknowledge level
    a_r7_ack_pair: assert property (@(posedge clk) disable iff (rst)
        jn_a_ack == jn_b_ack);
endmodule

// File: tb/tp_forkjoin_bench.sv
module tp_forkjoin_bench;
    localparam int W = 8;
    localparam int NV = 16;
    localparam logic [W-1:0] VEC [NV] = '{
        8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h01, 8'h80, 8'h3C, 8'hC3,
        8'h7E, 8'h81, 8'h12, 8'h34, 8'hF0, 8'h0F, 8'hAA, 8'h55
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic           fk_src_req = 0;
    logic [W-1:0]   fk_src_data = 0;
    logic           fk_src_ack;
    logic [1:0]     fk_br_req;
    logic [W-1:0]   fk_br_data;
    logic [1:0]     fk_br_ack = 0;
    logic           jn_a_req = 0, jn_b_req = 0;
    logic [W-1:0]   jn_a_data = 0, jn_b_data = 0;
    logic           jn_a_ack, jn_b_ack;
    logic           jn_dst_req;
    logic [2*W-1:0] jn_dst_data;
    logic           jn_dst_ack = 0;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit mon_en = 0;
    int ack_seen = 0;
    logic ack_prev = 0;

    always #10 clk = ~clk;

    tp_forkjoin #(.W(W)) u_tp_forkjoin (
        .clk(clk), .rst(rst),
        .fk_src_req(fk_src_req), .fk_src_data(fk_src_data), .fk_src_ack(fk_src_ack),
        .fk_br_req(fk_br_req), .fk_br_data(fk_br_data), .fk_br_ack(fk_br_ack),
        .jn_a_req(jn_a_req), .jn_a_data(jn_a_data), .jn_a_ack(jn_a_ack),
        .jn_b_req(jn_b_req), .jn_b_data(jn_b_data), .jn_b_ack(jn_b_ack),
        .jn_dst_req(jn_dst_req), .jn_dst_data(jn_dst_data), .jn_dst_ack(jn_dst_ack)
    );

    always @(negedge clk) begin
        if (rst) ack_prev = 1'b0;
        else if (fk_src_ack != ack_prev) begin
            ack_prev = fk_src_ack;
            if (mon_en) ack_seen++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        fk_src_req = 0; fk_src_data = 0; fk_br_ack = 0;
        jn_a_req = 0; jn_b_req = 0; jn_a_data = 0; jn_b_data = 0; jn_dst_ack = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic source(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            fk_src_data = VEC[k];
            fk_src_req = ~fk_src_req;
            do @(negedge clk); while (fk_src_ack != fk_src_req);
        end
    endtask

    // Branch A forwards the word; branch B forwards its complement.
    task automatic branch(input bit sel, input int n);
        for (int k = 0; k < n; k++) begin
            int stall;
            if (sel == 1'b0) begin
                do @(negedge clk); while (!((fk_br_req[0] != fk_br_ack[0]) && (jn_a_req == jn_a_ack)));
                stall = (k * 3) % 4;
            end else begin
                do @(negedge clk); while (!((fk_br_req[1] != fk_br_ack[1]) && (jn_b_req == jn_b_ack)));
                stall = (k * 7 + 1) % 5;
            end
            repeat (stall) @(negedge clk);
            if (sel == 1'b0) begin
                jn_a_data = fk_br_data;
                jn_a_req = ~jn_a_req;
                fk_br_ack[0] = ~fk_br_ack[0];
            end else begin
                jn_b_data = ~fk_br_data;
                jn_b_req = ~jn_b_req;
                fk_br_ack[1] = ~fk_br_ack[1];
            end
        end
    endtask

    task automatic sink(input int n);
        for (int k = 0; k < n; k++) begin
            logic [2*W-1:0] exp;
            do @(negedge clk); while (jn_dst_req == jn_dst_ack);
            exp = {VEC[k], ~VEC[k]};
            check(jn_dst_data == exp, "R8 word reassembly", 32'(jn_dst_data), 32'(exp));
            repeat (k % 3) @(negedge clk);
            jn_dst_ack = ~jn_dst_ack;
        end
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        @(negedge clk);
        check(fk_src_ack == 0, "R1 fork ack", 32'(fk_src_ack), 0);
        check(jn_dst_req == 0, "R1 join req", 32'(jn_dst_req), 0);
        check(jn_dst_data == 0, "R1 join data", 32'(jn_dst_data), 0);
        check({jn_a_ack, jn_b_ack} == 0, "R1 join acks", 32'({jn_a_ack, jn_b_ack}), 0);

        // R2: fan-out
        fk_src_data = 8'h3C; fk_src_req = 1;
        #1;
        check(fk_br_req == 2'b11, "R2 branch req", 32'(fk_br_req), 3);
        check(fk_br_data == 8'h3C, "R2 branch data", 32'(fk_br_data), 32'h3C);

        // R4: one branch acknowledge alone
        @(negedge clk); fk_br_ack[0] = 1;
        repeat (3) @(negedge clk);
        check(fk_src_ack == 0, "R4 ack held", 32'(fk_src_ack), 0);

        // R3: second branch completes the phase, registered one edge later
        fk_br_ack[1] = 1;
        #1;
        check(fk_src_ack == 0, "R3 not before edge", 32'(fk_src_ack), 0);
        @(negedge clk);
        check(fk_src_ack == 1, "R3 ack after edge", 32'(fk_src_ack), 1);

        // R3 falling phase, branch B first
        fk_src_req = 0;
        @(negedge clk); fk_br_ack[1] = 0;
        repeat (2) @(negedge clk);
        check(fk_src_ack == 1, "R4 ack held falling", 32'(fk_src_ack), 1);
        fk_br_ack[0] = 0;
        @(negedge clk);
        check(fk_src_ack == 0, "R3 ack falling", 32'(fk_src_ack), 0);

        // R5: one producer request alone
        jn_a_data = 8'hAA; jn_a_req = 1;
        repeat (3) @(negedge clk);
        check(jn_dst_req == 0, "R5 req held", 32'(jn_dst_req), 0);
        jn_b_data = 8'h55; jn_b_req = 1;
        @(negedge clk);
        check(jn_dst_req == 1, "R5 req after both", 32'(jn_dst_req), 1);
        check(jn_dst_data == 16'hAA55, "R6 field order", 32'(jn_dst_data), 32'hAA55);

        // R7: consumer acknowledge reaches both producers
        jn_dst_ack = 1;
        #1;
        check(jn_a_ack == 1 && jn_b_ack == 1, "R7 ack to both", 32'({jn_a_ack, jn_b_ack}), 3);

        // R6: field change without request does not alter the word
        @(negedge clk); jn_a_data = 8'h11; jn_b_data = 8'h22;
        repeat (3) @(negedge clk);
        check(jn_dst_data == 16'hAA55, "R6 word stable", 32'(jn_dst_data), 32'hAA55);

        // R5 / R6 falling phase, B first
        jn_b_req = 0;
        repeat (2) @(negedge clk);
        check(jn_dst_req == 1, "R5 req held falling", 32'(jn_dst_req), 1);
        jn_a_req = 0;
        @(negedge clk);
        check(jn_dst_req == 0, "R5 req falling", 32'(jn_dst_req), 0);
        check(jn_dst_data == 16'h1122, "R6 recapture", 32'(jn_dst_data), 32'h1122);

        // R8: fork -> two stalling branches -> join, walking the vector table
        do_reset();
        mon_en = 1;
        fork
            source(NV);
            branch(1'b0, NV);
            branch(1'b1, NV);
            sink(NV);
        join
        repeat (3) @(negedge clk);
        check(ack_seen == NV, "R8 one ack per word", 32'(ack_seen), 32'(NV));

        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule